// File: doc/BRIEF.md
# Power State and Wake Signal Controller

This block holds the power-management state of a network controller and derives two things from it. The first is the set of decode enables for the I/O, memory and expansion-ROM spaces, which are live only in the full-power state. The second is the PME status and the external LAN wake pin, which are raised when a wake event such as a matched wake-up frame arrives. State changes written by the host take effect on the next clock edge, with no settling delay. A power-loss input marks the cold-off state. After that, only a reset brings the block back to full power.

The PME enable and PME status bits are sticky. They survive the ordinary reset and are cleared only by power loss. The wake pin can be enabled or disabled by a bit loaded from nonvolatile memory. It has two modes, chosen by bit 4 of a configuration byte. In the first mode it follows wake events directly. In the second it mirrors PME while the isolate input is low. All interfaces are plain control and status pins. No data stream passes through the block, so there is no valid/ready handshake.

Top module: `pmw_power_wake`

## Requirements
- R1: With `pwr_lost` low, a cycle with `rst_n` low sets `pwr_state` to 00 (full power) and clears `d3cold` at the next edge. It also clears the wake mode bit and `wake_out`.
- R2: A cycle with `pwr_lost` high sets `d3cold`, sets `pwr_state` to 11 and clears PME enable, PME status, the wake mode and `wake_out` at the next edge. While `d3cold` is set, all three decode enables are 0.
- R3: A write with `pm_wr` high, outside cold-off, loads `pm_wdata[1:0]` as the new state on the next edge: 00 full power, 01 light sleep, 10 deep sleep, 11 hot off. Each decode enable equals its command bit when the state is 00 and is 0 in every other state.
- R4: `wake_evt` sets PME status at the next edge when PME enable is 1. In state 00 this happens only if `ee_pme_d0_cap` is 1 and `acpi_mode` is 0. `pme_d0_cap` reports `ee_pme_d0_cap & ~acpi_mode`.
- R5: A `pm_wr` write loads PME enable from `pm_wdata[2]`. The same write clears PME status when `pm_wdata[3]` is 1 and leaves it unchanged when that bit is 0. If a setting wake event arrives in the same cycle, the event wins. `pme_active` is PME enable AND PME status.
- R6: PME enable and PME status keep their values through a reset that is not accompanied by power loss.
- R7: With `ee_wake_en` 1 and wake mode 0, `wake_out` is 1 from the edge after `wake_evt`. It stays 1 until a `pm_wr` write with `pm_wdata[3]` = 1 clears it, or until `ee_wake_en` drops.
- R8: With `ee_wake_en` 1 and wake mode 1, `wake_out` at each edge takes the value of `pme_active & ~isolate` sampled at that edge. A `cfg_wr` write loads the wake mode from `cfg_wdata[4]`.
- R9: With `ee_wake_en` 0, `wake_out` is 0 from the next edge and wake events do not raise it.
- R10: While `d3cold` is set, `pm_wr` writes change neither the state nor the PME bits. This lasts until a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_lost | input | 1 | Main power lost (cold-off indication) |
| pm_wr | input | 1 | Power-management control write strobe |
| pm_wdata | input | 4 | [1:0] state, [2] PME enable, [3] PME status clear |
| cfg_wr | input | 1 | Configuration byte write strobe |
| cfg_wdata | input | 8 | Configuration byte; bit 4 picks wake mode |
| ee_wake_en | input | 1 | Nonvolatile wake-pin enable |
| ee_pme_d0_cap | input | 1 | Nonvolatile PME-from-full-power capability |
| acpi_mode | input | 1 | Operating under ACPI |
| cmd_io | input | 1 | Host I/O decode command bit |
| cmd_mem | input | 1 | Host memory decode command bit |
| cmd_rom | input | 1 | Host expansion-ROM decode command bit |
| wake_evt | input | 1 | Wake event strobe |
| isolate | input | 1 | Isolate input (wake blocked while high in mode 1) |
| pwr_state | output | 2 | Current power state |
| d3cold | output | 1 | Cold-off flag |
| io_dec_en | output | 1 | I/O space decode enable |
| mem_dec_en | output | 1 | Memory space decode enable |
| rom_dec_en | output | 1 | Expansion-ROM decode enable |
| pme_d0_cap | output | 1 | Reported PME capability in full power |
| pme_sts | output | 1 | PME status |
| pme_active | output | 1 | PME asserted |
| wake_out | output | 1 | LAN wake pin |

## Verification
The main function is the decision of when the wake pin and PME status rise and fall. The first pattern is a wake event with PME disabled. Mode 0 should raise the pin and mode 1 should not, which shows whether the pin depends on PME or only on the event. The second pattern toggles `isolate` while PME is active, which shows that the pin follows isolation only in mode 1. The third pattern puts a status clear and a wake event in the same cycle, which shows the priority between them. Events in full power under ACPI confirm that PME is blocked in that state. A long stretch of weighted random traffic with rare resets and power losses then compares every output against a bench model cycle by cycle.

// File: rtl/pmw_pkg.sv
package pmw_pkg;
  typedef enum logic [1:0] {
    PS_D0    = 2'b00,
    PS_D1    = 2'b01,
    PS_D2    = 2'b10,
    PS_D3HOT = 2'b11
  } pstate_e;

  localparam int PM_W        = 4;
  localparam int PM_EN_BIT   = 2;
  localparam int PM_CLR_BIT  = 3;
  localparam int NUM_SPACES  = 3;
endpackage

// File: rtl/pmw_state.sv
module pmw_state
  import pmw_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    pwr_lost,
  input  logic    wr,
  input  pstate_e wr_state,
  output pstate_e state,
  output logic    d3cold
);
  always_ff @(posedge clk) begin
    if (pwr_lost) begin
      state  <= PS_D3HOT;
      d3cold <= 1'b1;
    end else if (!rst_n) begin
      state  <= PS_D0;
      d3cold <= 1'b0;
    end else if (wr && !d3cold) begin
      state  <= wr_state;
    end
  end

  assert_reset_d0_R1: assert property (@(posedge clk) disable iff (pwr_lost)
    !rst_n |=> (state == PS_D0) && !d3cold);
  assert_cold_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_lost |=> d3cold && (state == PS_D3HOT));
  assert_write_now_R3: assert property (@(posedge clk) disable iff (!rst_n || pwr_lost)
    (wr && !d3cold) |=> state == $past(wr_state));
  assert_cold_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n || pwr_lost)
    d3cold |=> $stable(state) && d3cold);
endmodule

// File: rtl/pmw_pme.sv
module pmw_pme
  import pmw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_lost,
  input  logic blocked,
  input  logic wr,
  input  logic wr_en,
  input  logic wr_clr,
  input  logic wake_evt,
  input  logic in_d0,
  input  logic d0_ok,
  output logic pme_en,
  output logic pme_sts
);
  logic set_sts;
  logic clr_sts;

  assign set_sts = wake_evt && pme_en && (!in_d0 || d0_ok);
  assign clr_sts = wr && wr_clr && !blocked;

  // Sticky: only power loss clears; ordinary reset just freezes them.
  always_ff @(posedge clk) begin
    if (pwr_lost) begin
      pme_en  <= 1'b0;
      pme_sts <= 1'b0;
    end else if (rst_n) begin
      if (wr && !blocked) pme_en <= wr_en;
      if (set_sts)        pme_sts <= 1'b1;
      else if (clr_sts)   pme_sts <= 1'b0;
    end
  end

  assert_evt_sets_R4: assert property (@(posedge clk) disable iff (!rst_n || pwr_lost)
    (wake_evt && pme_en && !in_d0) |=> pme_sts);
  assert_d0_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n || pwr_lost)
    (in_d0 && !d0_ok && !pme_sts) |=> !pme_sts);
  assert_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n || pwr_lost)
    (wr && wr_clr && !blocked && !wake_evt) |=> !pme_sts);
  assert_sticky_R6: assert property (@(posedge clk) disable iff (pwr_lost)
    !rst_n |=> $stable(pme_en) && $stable(pme_sts));
endmodule

// File: rtl/pmw_wake.sv
module pmw_wake #(
  parameter int CFG_W    = 8,
  parameter int MODE_BIT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_lost,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             pin_en,
  input  logic             wake_evt,
  input  logic             pme_clr,
  input  logic             pme_active,
  input  logic             isolate,
  output logic             mode,
  output logic             wake_q
);
  always_ff @(posedge clk) begin
    if (pwr_lost || !rst_n) mode <= 1'b0;
    else if (cfg_wr)        mode <= cfg_wdata[MODE_BIT];
  end

  always_ff @(posedge clk) begin
    if (pwr_lost || !rst_n)  wake_q <= 1'b0;
    else if (!pin_en)        wake_q <= 1'b0;
    else if (!mode) begin
      if (wake_evt)          wake_q <= 1'b1;
      else if (pme_clr)      wake_q <= 1'b0;
    end else                 wake_q <= pme_active && !isolate;
  end

  assert_direct_R7: assert property (@(posedge clk) disable iff (!rst_n || pwr_lost)
    (pin_en && !mode && wake_evt) |=> wake_q);
  assert_gated_R8: assert property (@(posedge clk) disable iff (!rst_n || pwr_lost)
    (pin_en && mode) |=> wake_q == $past(pme_active && !isolate));
  assert_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n || pwr_lost)
    !pin_en |=> !wake_q);
endmodule

// File: rtl/pmw_power_wake.sv
module pmw_power_wake
  import pmw_pkg::*;
#(
  parameter int CFG_W    = 8,
  parameter int MODE_BIT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_lost,
  input  logic             pm_wr,
  input  logic [PM_W-1:0]  pm_wdata,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             ee_wake_en,
  input  logic             ee_pme_d0_cap,
  input  logic             acpi_mode,
  input  logic             cmd_io,
  input  logic             cmd_mem,
  input  logic             cmd_rom,
  input  logic             wake_evt,
  input  logic             isolate,
  output logic [1:0]       pwr_state,
  output logic             d3cold,
  output logic             io_dec_en,
  output logic             mem_dec_en,
  output logic             rom_dec_en,
  output logic             pme_d0_cap,
  output logic             pme_sts,
  output logic             pme_active,
  output logic             wake_out
);
  pstate_e               state_q;
  logic                  cold_q;
  logic                  in_d0;
  logic                  d0_ok;
  logic                  pme_en_q;
  logic                  pme_sts_q;
  logic                  pme_clr;
  logic                  mode_q;
  logic                  wake_q;
  logic [NUM_SPACES-1:0] cmd_vec;
  logic [NUM_SPACES-1:0] dec_vec;

  pmw_state u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_lost (pwr_lost),
    .wr       (pm_wr),
    .wr_state (pstate_e'(pm_wdata[1:0])),
    .state    (state_q),
    .d3cold   (cold_q)
  );

  assign in_d0   = (state_q == PS_D0) && !cold_q;
  assign d0_ok   = ee_pme_d0_cap && !acpi_mode;
  assign pme_clr = pm_wr && pm_wdata[PM_CLR_BIT] && !cold_q;

  pmw_pme u_pme (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_lost (pwr_lost),
    .blocked  (cold_q),
    .wr       (pm_wr),
    .wr_en    (pm_wdata[PM_EN_BIT]),
    .wr_clr   (pm_wdata[PM_CLR_BIT]),
    .wake_evt (wake_evt),
    .in_d0    (in_d0),
    .d0_ok    (d0_ok),
    .pme_en   (pme_en_q),
    .pme_sts  (pme_sts_q)
  );

  pmw_wake #(.CFG_W(CFG_W), .MODE_BIT(MODE_BIT)) u_wake (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_lost   (pwr_lost),
    .cfg_wr     (cfg_wr),
    .cfg_wdata  (cfg_wdata),
    .pin_en     (ee_wake_en),
    .wake_evt   (wake_evt),
    .pme_clr    (pme_clr),
    .pme_active (pme_active),
    .isolate    (isolate),
    .mode       (mode_q),
    .wake_q     (wake_q)
  );

  assign cmd_vec = {cmd_rom, cmd_mem, cmd_io};
  for (genvar i = 0; i < NUM_SPACES; i++) begin : g_dec
    assign dec_vec[i] = cmd_vec[i] && in_d0;
  end

  assign io_dec_en  = dec_vec[0];
  assign mem_dec_en = dec_vec[1];
  assign rom_dec_en = dec_vec[2];
  assign pwr_state  = state_q;
  assign d3cold     = cold_q;
  assign pme_d0_cap = d0_ok;
  assign pme_sts    = pme_sts_q;
  assign pme_active = pme_en_q && pme_sts_q;
  assign wake_out   = wake_q;

  assert_low_power_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state != PS_D0) |-> !io_dec_en && !mem_dec_en && !rom_dec_en);
  assert_cold_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    d3cold |-> !io_dec_en && !mem_dec_en && !rom_dec_en);
endmodule

// File: tb/pmw_power_wake_bench.sv
module pmw_power_wake_bench;
  logic       clk = 1'b0;
  logic       rst_n, pwr_lost, pm_wr, cfg_wr;
  logic [3:0] pm_wdata;
  logic [7:0] cfg_wdata;
  logic       ee_wake_en, ee_pme_d0_cap, acpi_mode;
  logic       cmd_io, cmd_mem, cmd_rom, wake_evt, isolate;
  logic [1:0] pwr_state;
  logic       d3cold, io_dec_en, mem_dec_en, rom_dec_en;
  logic       pme_d0_cap, pme_sts, pme_active, wake_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model state
  logic [1:0] m_st;
  logic m_d3c, m_en, m_sts, m_mode, m_wake;

  always #5 clk = ~clk;

  pmw_power_wake u_pmw_power_wake (
    .clk(clk), .rst_n(rst_n), .pwr_lost(pwr_lost), .pm_wr(pm_wr), .pm_wdata(pm_wdata),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .ee_wake_en(ee_wake_en),
    .ee_pme_d0_cap(ee_pme_d0_cap), .acpi_mode(acpi_mode), .cmd_io(cmd_io),
    .cmd_mem(cmd_mem), .cmd_rom(cmd_rom), .wake_evt(wake_evt), .isolate(isolate),
    .pwr_state(pwr_state), .d3cold(d3cold), .io_dec_en(io_dec_en),
    .mem_dec_en(mem_dec_en), .rom_dec_en(rom_dec_en), .pme_d0_cap(pme_d0_cap),
    .pme_sts(pme_sts), .pme_active(pme_active), .wake_out(wake_out)
  );

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic exp_dec(logic cmd);
    return cmd && (m_st == 2'b00) && !m_d3c;
  endfunction

  function automatic logic exp_allow();
    return (m_st != 2'b00) || (ee_pme_d0_cap && !acpi_mode);
  endfunction

  task automatic compare_all();
    check("R3", "pwr_state", {6'd0, pwr_state}, {6'd0, m_st});
    check("R2", "d3cold", {7'd0, d3cold}, {7'd0, m_d3c});
    check("R3", "io_dec_en", {7'd0, io_dec_en}, {7'd0, exp_dec(cmd_io)});
    check("R3", "mem_dec_en", {7'd0, mem_dec_en}, {7'd0, exp_dec(cmd_mem)});
    check("R3", "rom_dec_en", {7'd0, rom_dec_en}, {7'd0, exp_dec(cmd_rom)});
    check("R4", "pme_d0_cap", {7'd0, pme_d0_cap}, {7'd0, ee_pme_d0_cap && !acpi_mode});
    check("R5", "pme_sts", {7'd0, pme_sts}, {7'd0, m_sts});
    check("R5", "pme_active", {7'd0, pme_active}, {7'd0, m_en && m_sts});
    check(m_mode ? "R8" : "R7", "wake_out", {7'd0, wake_out}, {7'd0, m_wake});
  endtask

  // one clock: model next state from pre-edge values, then compare
  task automatic cycle();
    logic [1:0] n_st;
    logic n_d3c, n_en, n_sts, n_mode, n_wake, clr;
    n_st = m_st; n_d3c = m_d3c; n_en = m_en; n_sts = m_sts; n_mode = m_mode; n_wake = m_wake;
    clr = pm_wr && pm_wdata[3] && !m_d3c;
    if (pwr_lost) begin
      n_st = 2'b11; n_d3c = 1'b1; n_en = 1'b0; n_sts = 1'b0; n_mode = 1'b0; n_wake = 1'b0;
    end else if (!rst_n) begin
      n_st = 2'b00; n_d3c = 1'b0; n_mode = 1'b0; n_wake = 1'b0;
    end else begin
      if (pm_wr && !m_d3c) begin n_st = pm_wdata[1:0]; n_en = pm_wdata[2]; end
      if (wake_evt && m_en && exp_allow()) n_sts = 1'b1;
      else if (clr) n_sts = 1'b0;
      if (cfg_wr) n_mode = cfg_wdata[4];
      if (!ee_wake_en) n_wake = 1'b0;
      else if (!m_mode) begin
        if (wake_evt) n_wake = 1'b1;
        else if (clr) n_wake = 1'b0;
      end else n_wake = m_en && m_sts && !isolate;
    end
    @(posedge clk);
    #2;
    m_st = n_st; m_d3c = n_d3c; m_en = n_en; m_sts = n_sts; m_mode = n_mode; m_wake = n_wake;
    compare_all();
    pm_wr = 1'b0; cfg_wr = 1'b0; wake_evt = 1'b0;
  endtask

  task automatic pm_write(logic [3:0] d);
    pm_wr = 1'b1; pm_wdata = d; cycle();
  endtask

  task automatic cfg_write(logic [7:0] d);
    cfg_wr = 1'b1; cfg_wdata = d; cycle();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1b2c3d4e));
    m_st = 2'b00; m_d3c = 1'b0; m_en = 1'b0; m_sts = 1'b0; m_mode = 1'b0; m_wake = 1'b0;
    rst_n = 1'b0; pwr_lost = 1'b1; pm_wr = 1'b0; pm_wdata = 4'h0; cfg_wr = 1'b0;
    cfg_wdata = 8'h00; ee_wake_en = 1'b1; ee_pme_d0_cap = 1'b1; acpi_mode = 1'b0;
    cmd_io = 1'b1; cmd_mem = 1'b1; cmd_rom = 1'b1; wake_evt = 1'b0; isolate = 1'b0;
    #1;
    cycle();
    check("R2", "cold after power loss", {6'd0, pwr_state}, 8'h03);
    pwr_lost = 1'b0;
    cycle();
    rst_n = 1'b1;
    cycle();
    // R1: reset leaves full power with decodes live
    check("R1", "state after reset", {6'd0, pwr_state}, 8'h00);
    check("R1", "io decode after reset", {7'd0, io_dec_en}, 8'h01);

    // R3: light sleep and deep sleep kill decodes, full power restores
    pm_write(4'b0010);
    check("R3", "mem decode in deep sleep", {7'd0, mem_dec_en}, 8'h00);
    pm_write(4'b0000);
    check("R3", "rom decode back in full power", {7'd0, rom_dec_en}, 8'h01);

    // R7 mode 0: event raises pin even with PME disabled
    wake_evt = 1'b1; cycle();
    check("R7", "direct wake pin", {7'd0, wake_out}, 8'h01);
    check("R4", "no status with PME off", {7'd0, pme_sts}, 8'h00);
    pm_write(4'b1000);
    check("R7", "wake pin cleared by W1C", {7'd0, wake_out}, 8'h00);

    // R4: PME enabled in light sleep
    pm_write(4'b0101);
    wake_evt = 1'b1; cycle();
    check("R4", "status set in light sleep", {7'd0, pme_sts}, 8'h01);
    // R5: clear and event together, event wins
    pm_wr = 1'b1; pm_wdata = 4'b1101; wake_evt = 1'b1; cycle();
    check("R5", "event beats clear", {7'd0, pme_sts}, 8'h01);
    pm_write(4'b1101);
    check("R5", "W1C clears", {7'd0, pme_sts}, 8'h00);

    // R4: full power under ACPI blocks PME
    acpi_mode = 1'b1;
    pm_write(4'b0100);
    check("R4", "d0 cap hidden under ACPI", {7'd0, pme_d0_cap}, 8'h00);
    wake_evt = 1'b1; cycle();
    check("R4", "no PME from full power under ACPI", {7'd0, pme_sts}, 8'h00);
    acpi_mode = 1'b0;

    // R8 mode 1: pin follows PME while isolate low
    cfg_write(8'h10);
    pm_write(4'b0111);
    isolate = 1'b1;
    wake_evt = 1'b1; cycle();
    cycle();
    check("R8", "pin held off by isolate", {7'd0, wake_out}, 8'h00);
    isolate = 1'b0; cycle();
    check("R8", "pin follows PME", {7'd0, wake_out}, 8'h01);

    // R9: nonvolatile disable forces pin low
    ee_wake_en = 1'b0; cycle();
    check("R9", "pin disabled", {7'd0, wake_out}, 8'h00);
    ee_wake_en = 1'b1;

    // R6: status survives ordinary reset
    rst_n = 1'b0; cycle();
    rst_n = 1'b1; cycle();
    check("R6", "status sticky over reset", {7'd0, pme_sts}, 8'h01);
    check("R6", "state full power after reset", {6'd0, pwr_state}, 8'h00);

    // R10: writes ignored in cold-off until reset
    pwr_lost = 1'b1; cycle();
    pwr_lost = 1'b0;
    pm_write(4'b0101);
    check("R10", "state frozen in cold-off", {6'd0, pwr_state}, 8'h03);
    check("R10", "enable frozen in cold-off", {7'd0, pme_active}, 8'h00);
    rst_n = 1'b0; cycle();
    rst_n = 1'b1; cycle();
    check("R1", "cold-off left by reset", {7'd0, d3cold}, 8'h00);

    // weighted random traffic
    for (int i = 0; i < 4000; i++) begin
      pwr_lost      = ($urandom % 300) == 0;
      rst_n         = ($urandom % 120) != 0;
      pm_wr         = ($urandom % 6) == 0;
      pm_wdata      = 4'($urandom);
      cfg_wr        = ($urandom % 15) == 0;
      cfg_wdata     = 8'($urandom);
      if (($urandom % 40) == 0) ee_wake_en = ~ee_wake_en;
      if (($urandom % 50) == 0) acpi_mode = ~acpi_mode;
      if (($urandom % 50) == 0) ee_pme_d0_cap = ~ee_pme_d0_cap;
      cmd_io        = 1'($urandom);
      cmd_mem       = 1'($urandom);
      cmd_rom       = 1'($urandom);
      wake_evt      = ($urandom % 5) == 0;
      isolate       = ($urandom % 3) == 0;
      cycle();
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule